// File: doc/BRIEF.md
# SMBus Byte-Register Target

This block is a target-only two-wire serial port for a point-of-load regulator. Only two transactions are understood. The first writes one byte: the target address, then a register index, then a data byte. The second reads one byte: the target address, then a register index, then a repeated START, the target address with the read flag, and one data byte returned by the target. Bus lines are oversampled by the system clock. The target answers only by pulling SDA low through an open-drain enable. It never holds SCL.

The bank has four registers. The first is an output-voltage code protected by a parity bit. Two control registers hold the regulator options. The last is a read-only status byte taken from live inputs. The stored registers are presented as ports for the regulator logic. Two pins pick the low two bits of the 7-bit target address. A parity error in a voltage write is refused with a NACK. An accepted voltage write also switches the regulator from external-divider regulation to register-driven regulation.

Top module: `smb_reg_slave`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal binary 01101 followed by `addr_sel_i[1]` and then `addr_sel_i[0]`, which covers 0x34 to 0x37. Bit 0 of that byte selects read (1) or write (0).
- R2: After an address that does not match, the target drives no ACK on any later byte and changes no register until the next START.
- R3: Register indices 0 (voltage), 8 (control A), 9 (control B) and 24 (status) are acknowledged. Any other index gets no ACK, and the data that follows is ignored.
- R4: A data byte for index 0 is accepted only if bit 7 equals the XNOR of bits 6:0, which gives an odd count of ones. Otherwise it gets no ACK and the voltage register keeps its value.
- R5: An accepted voltage write sets control A bit 7 (internal-regulation flag). A refused voltage write leaves that bit unchanged.
- R6: Index 24 is read-only: a data byte written to it gets no ACK. Reading it returns {5'b0, `stat_i[2:0]`}.
- R7: Reset values are voltage 0x32 (code 0110010, parity bit 0), control A 0x73 and control B 0x67. Control A layout: bit 7 internal, 6:5 power-good delay, 4 hiccup, 3 eco, 1:0 DAC settle, bit 2 reserved. Control B layout: bit 7 enable, 6 OV latch-off disable, 5 UV latch-off disable, 2:0 current limit, bits 4:3 reserved.
- R8: A read shifts out the selected register MSB first, with the voltage register's parity bit in bit 7. From the master's ACK/NACK slot until the next START, the target leaves SDA released.
- R9: Before SCL and SDA have been seen high together for `ARM_CYCLES` consecutive synchronised samples, the target ignores START conditions and drives no ACK.
- R10: A repeated START behaves like a START. The register index written before it is the one that the read returns.
- R11: A control-register write is accepted without any parity check. The reserved bits are stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel_i | input | 2 | Low two bits of the target address |
| stat_i | input | 3 | Live status: bit 2 over-temperature shutdown, bit 1 over-temperature warning, bit 0 power good |
| sda_pull_o | output | 1 | High pulls SDA low (open drain) |
| vout_reg_o | output | 8 | Stored voltage register, parity in bit 7 |
| ctrl_a_o | output | 8 | Stored control A register |
| ctrl_b_o | output | 8 | Stored control B register |

## Verification
The assertions assume that SDA changes only while SCL is low, except at START and STOP. They also assume that each SCL level lasts longer than the synchroniser depth plus one cycle, so that every edge is seen once. The stimulus meets both by holding every bus phase for six clocks and changing SDA only in the middle of the SCL low phase. One exception is deliberate: the power-up sequence makes a two-cycle SDA pulse while SCL is high, to show that an unarmed bus ignores it.

// File: rtl/smb_pkg.sv
package smb_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] IDX_VOUT = 8'd0;
    localparam logic [BYTE_W-1:0] IDX_CTLA = 8'd8;
    localparam logic [BYTE_W-1:0] IDX_CTLB = 8'd9;
    localparam logic [BYTE_W-1:0] IDX_STAT = 8'd24;

    localparam logic [BYTE_W-1:0] VOUT_RST = 8'h32;
    localparam logic [BYTE_W-1:0] CTLA_RST = 8'h73;
    localparam logic [BYTE_W-1:0] CTLB_RST = 8'h67;
    localparam logic [BYTE_W-1:0] CTLA_KEEP = 8'hFB;
    localparam logic [BYTE_W-1:0] CTLB_KEEP = 8'hE7;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_ADDR,
        XS_INDEX,
        XS_WDATA,
        XS_RDATA,
        XS_SKIP
    } xfer_state_e;

    function automatic logic index_known(logic [BYTE_W-1:0] idx);
        return (idx == IDX_VOUT) || (idx == IDX_CTLA) ||
               (idx == IDX_CTLB) || (idx == IDX_STAT);
    endfunction

    function automatic logic parity_good(logic [BYTE_W-1:0] b);
        return b[7] == ~^b[6:0];
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
    parameter int SYNC_STAGES = 2,
    parameter int ARM_CYCLES  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o,
    output logic armed_o
);
    localparam int CNT_W = $clog2(ARM_CYCLES + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_last;
        logic                   sda_last;
        logic [CNT_W-1:0]       arm_cnt;
        logic                   armed;
    } sync_t;

    sync_t q, d;
    logic  scl_now, sda_now;

    assign scl_now = q.scl_pipe[SYNC_STAGES-1];
    assign sda_now = q.sda_pipe[SYNC_STAGES-1];

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        d.scl_last = scl_now;
        d.sda_last = sda_now;
        if (!q.armed) begin
            if (scl_now && sda_now) begin
                if (q.arm_cnt == CNT_W'(ARM_CYCLES - 1)) begin
                    d.armed = 1'b1;
                end else begin
                    d.arm_cnt = q.arm_cnt + 1'b1;
                end
            end else begin
                d.arm_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sda_s_o    = sda_now;
    assign scl_rise_o = scl_now & ~q.scl_last;
    assign scl_fall_o = ~scl_now & q.scl_last;
    assign start_o    = q.armed & scl_now & q.scl_last & q.sda_last & ~sda_now;
    assign stop_o     = q.armed & scl_now & q.scl_last & ~q.sda_last & sda_now;
    assign armed_o    = q.armed;

    assert_armed_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(q.armed));

    assert_arm_needs_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.armed) |-> $past(scl_now && sda_now));

endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
    import smb_pkg::*;
#(
    parameter logic [4:0] ADDR_HI = 5'b01101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start,
    input  logic              stop,
    input  logic              sda_s,
    input  logic              armed,
    input  logic [1:0]        addr_sel,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_pull,
    output logic              wr_en,
    output logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ptr
);
    localparam logic [3:0] LAST_BIT = 4'd8;
    localparam logic [3:0] ACK_BIT  = 4'd9;

    typedef struct packed {
        xfer_state_e       st;
        xfer_state_e       after;
        logic [3:0]        bitcnt;
        logic [BYTE_W-1:0] shreg;
        logic [BYTE_W-1:0] ptr;
        logic              pull;
        logic              wr_en;
        logic [BYTE_W-1:0] wr_data;
    } fsm_t;

    fsm_t q, d;
    logic addr_hit;
    logic data_ok;

    assign addr_hit = q.shreg[7:1] == {ADDR_HI, addr_sel};
    assign data_ok  = (q.ptr == IDX_STAT) ? 1'b0 :
                      (q.ptr == IDX_VOUT) ? parity_good(q.shreg) : 1'b1;

    always_comb begin
        d       = q;
        d.wr_en = 1'b0;
        if (start) begin
            d.st     = XS_ADDR;
            d.bitcnt = '0;
            d.pull   = 1'b0;
        end else if (stop) begin
            d.st   = XS_IDLE;
            d.pull = 1'b0;
        end else begin
            case (q.st)
                XS_ADDR, XS_INDEX, XS_WDATA: begin
                    if (scl_rise && q.bitcnt < ACK_BIT) begin
                        if (q.bitcnt < LAST_BIT) begin
                            d.shreg = {q.shreg[6:0], sda_s};
                        end
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                    if (scl_fall && q.bitcnt == LAST_BIT) begin
                        if (q.st == XS_ADDR) begin
                            if (addr_hit) begin
                                d.pull  = 1'b1;
                                d.after = q.shreg[0] ? XS_RDATA : XS_INDEX;
                            end else begin
                                d.st = XS_SKIP;
                            end
                        end else if (q.st == XS_INDEX) begin
                            if (index_known(q.shreg)) begin
                                d.pull  = 1'b1;
                                d.ptr   = q.shreg;
                                d.after = XS_WDATA;
                            end else begin
                                d.st = XS_SKIP;
                            end
                        end else begin
                            if (data_ok) begin
                                d.pull    = 1'b1;
                                d.wr_en   = 1'b1;
                                d.wr_data = q.shreg;
                                d.after   = XS_SKIP;
                            end else begin
                                d.st = XS_SKIP;
                            end
                        end
                    end else if (scl_fall && q.bitcnt == ACK_BIT) begin
                        d.pull   = 1'b0;
                        d.bitcnt = '0;
                        d.st     = q.after;
                        if (q.after == XS_RDATA) begin
                            d.shreg = rd_data;
                            d.pull  = ~rd_data[7];
                        end
                    end
                end
                XS_RDATA: begin
                    if (scl_rise) begin
                        if (q.bitcnt == LAST_BIT) begin
                            d.st = XS_SKIP;
                        end
                        d.bitcnt = q.bitcnt + 1'b1;
                    end
                    if (scl_fall) begin
                        if (q.bitcnt == LAST_BIT) begin
                            d.pull = 1'b0;
                        end else if (q.bitcnt != '0) begin
                            d.shreg = {q.shreg[6:0], 1'b0};
                            d.pull  = ~q.shreg[6];
                        end
                    end
                end
                default: begin
                    d.pull = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: XS_IDLE, after: XS_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign sda_pull = q.pull;
    assign wr_en    = q.wr_en;
    assign wr_data  = q.wr_data;
    assign ptr      = q.ptr;

    assert_quiet_until_armed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !q.pull);

    assert_parity_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wr_en && q.ptr == IDX_VOUT) |-> parity_good(q.wr_data));

    assert_status_never_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
        q.wr_en |-> q.ptr != IDX_STAT);

    assert_drive_after_scl_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pull) |-> $past(scl_fall));

    assert_released_after_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == XS_SKIP) |-> !q.pull);

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_ptr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [2:0]        stat_i,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] vout_o,
    output logic [BYTE_W-1:0] ctla_o,
    output logic [BYTE_W-1:0] ctlb_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] vout;
        logic [BYTE_W-1:0] ctla;
        logic [BYTE_W-1:0] ctlb;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_ptr)
                IDX_VOUT: begin
                    d.vout    = wr_data;
                    d.ctla[7] = 1'b1;
                end
                IDX_CTLA: d.ctla = wr_data & CTLA_KEEP;
                IDX_CTLB: d.ctlb = wr_data & CTLB_KEEP;
                default:  d = q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{vout: VOUT_RST, ctla: CTLA_RST, ctlb: CTLB_RST};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (wr_ptr)
            IDX_VOUT: rd_data = q.vout;
            IDX_CTLA: rd_data = q.ctla;
            IDX_CTLB: rd_data = q.ctlb;
            IDX_STAT: rd_data = {5'b0, stat_i};
            default:  rd_data = '0;
        endcase
    end

    assign vout_o = q.vout;
    assign ctla_o = q.ctla;
    assign ctlb_o = q.ctlb;

    assert_vout_parity_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        parity_good(q.vout));

    assert_vout_sets_internal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ptr == IDX_VOUT) |=> q.ctla[7]);

    assert_reserved_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.ctla & ~CTLA_KEEP) == '0) && ((q.ctlb & ~CTLB_KEEP) == '0));

    assert_internal_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ctla[7]) |-> $past(wr_en));

endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave
    import smb_pkg::*;
#(
    parameter logic [4:0] ADDR_HI     = 5'b01101,
    parameter int         SYNC_STAGES = 2,
    parameter int         ARM_CYCLES  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] addr_sel_i,
    input  logic [2:0] stat_i,
    output logic       sda_pull_o,
    output logic [7:0] vout_reg_o,
    output logic [7:0] ctrl_a_o,
    output logic [7:0] ctrl_b_o
);
    logic              sda_s, scl_rise, scl_fall, start, stop, armed;
    logic              wr_en;
    logic [BYTE_W-1:0] wr_data, ptr, rd_data;

    smb_line_sync #(
        .SYNC_STAGES(SYNC_STAGES),
        .ARM_CYCLES (ARM_CYCLES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s_o   (sda_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start),
        .stop_o    (stop),
        .armed_o   (armed)
    );

    smb_xfer_fsm #(
        .ADDR_HI(ADDR_HI)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start   (start),
        .stop    (stop),
        .sda_s   (sda_s),
        .armed   (armed),
        .addr_sel(addr_sel_i),
        .rd_data (rd_data),
        .sda_pull(sda_pull_o),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ptr     (ptr)
    );

    smb_reg_bank u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_ptr (ptr),
        .wr_data(wr_data),
        .stat_i (stat_i),
        .rd_data(rd_data),
        .vout_o (vout_reg_o),
        .ctla_o (ctrl_a_o),
        .ctlb_o (ctrl_b_o)
    );

endmodule

// File: tb/smb_reg_slave_test.sv
module smb_reg_slave_test;

    localparam int Q = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b0;
    logic [1:0] sel = 2'b00;
    logic [2:0] stat = 3'b000;
    logic       sda_pull;
    logic [7:0] vout_o, ca_o, cb_o;
    wire        sda_line = sda_m & ~sda_pull;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] vout_m = 8'h32;
    logic [7:0] ca_m   = 8'h73;
    logic [7:0] cb_m   = 8'h67;

    always #5 clk = ~clk;

    smb_reg_slave uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .addr_sel_i(sel),
        .stat_i    (stat),
        .sda_pull_o(sda_pull),
        .vout_reg_o(vout_o),
        .ctrl_a_o  (ca_o),
        .ctrl_b_o  (cb_o)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(2 * Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic get_byte(output logic [7:0] b, output logic released);
        sda_m = 1'b1; tick(Q);
        for (int i = 7; i >= 0; i--) begin
            scl_m = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            scl_m = 1'b0; tick(2 * Q);
        end
        scl_m = 1'b1; tick(Q);
        released = sda_line;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    function automatic bit addr_hit(logic [6:0] a, logic [1:0] s);
        return a == {5'b01101, s};
    endfunction

    function automatic bit idx_known(logic [7:0] r);
        return r == 8'd0 || r == 8'd8 || r == 8'd9 || r == 8'd24;
    endfunction

    function automatic bit data_accept(logic [7:0] r, logic [7:0] d);
        if (r == 8'd0) return d[7] == ~^d[6:0];
        return r == 8'd8 || r == 8'd9;
    endfunction

    function automatic logic [7:0] with_parity(logic [7:0] d);
        return {~^d[6:0], d[6:0]};
    endfunction

    function automatic logic [7:0] model_read(logic [7:0] r);
        case (r)
            8'd0:    return vout_m;
            8'd8:    return ca_m;
            8'd9:    return cb_m;
            default: return {5'b0, stat};
        endcase
    endfunction

    task automatic check_ports(string req);
        check(req, "vout port", vout_o, vout_m);
        check(req, "ctrl A port", ca_o, ca_m);
        check(req, "ctrl B port", cb_o, cb_m);
    endtask

    task automatic write_txn(string req, logic [6:0] a7, logic [7:0] r, logic [7:0] d);
        logic k0, k1, k2;
        bit   e0, e1, e2;
        bus_start();
        put_byte({a7, 1'b0}, k0);
        put_byte(r, k1);
        put_byte(d, k2);
        bus_stop();
        e0 = addr_hit(a7, sel);
        e1 = e0 && idx_known(r);
        e2 = e1 && data_accept(r, d);
        check(req, "address ack", k0, e0);
        check(req, "index ack", k1, e1);
        check(req, "data ack", k2, e2);
        if (e2) begin
            case (r)
                8'd0: begin vout_m = d; ca_m[7] = 1'b1; end
                8'd8: ca_m = d & 8'hFB;
                default: cb_m = d & 8'hE7;
            endcase
        end
        check_ports(req);
    endtask

    task automatic read_txn(string req, logic [7:0] r);
        logic       k0, k1, k2, rel;
        logic [7:0] got;
        bus_start();
        put_byte({5'b01101, sel, 1'b0}, k0);
        put_byte(r, k1);
        bus_start();
        put_byte({5'b01101, sel, 1'b1}, k2);
        get_byte(got, rel);
        bus_stop();
        check(req, "read acks", {k0, k1, k2}, 3'b111);
        check(req, "read data", got, model_read(r));
        check("R8", "sda released in master ack slot", rel, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic       k;
        logic [7:0] r, dv;
        logic [6:0] a7;
        void'($urandom(32'd4711));

        tick(4);
        rst_n = 1'b1;
        tick(2);
        check_ports("R7");

        // R9: SCL high and SDA low from reset, then a short SDA pulse that looks like a START
        tick(20);
        sda_m = 1'b1; tick(2);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
        put_byte(8'h68, k);
        check("R9", "no ack before bus armed", k, 1'b0);
        bus_stop();

        // R7: reset values seen on the bus
        read_txn("R7", 8'd0);
        read_txn("R7", 8'd8);
        read_txn("R7", 8'd9);

        // R1: other address pin value
        sel = 2'b10;
        write_txn("R1", 7'h36, 8'd9, 8'h85);
        read_txn("R1", 8'd9);

        // R2: wrong address, valid payload must be ignored
        write_txn("R2", 7'h35, 8'd0, with_parity(8'h10));
        write_txn("R2", 7'h76, 8'd8, 8'h00);

        // R4/R5: bad parity refused, internal flag stays clear
        write_txn("R4", 7'h36, 8'd0, {with_parity(8'h45)} ^ 8'h80);
        check("R5", "internal flag after refused write", ca_o[7], 1'b0);

        // R5: valid voltage write sets the internal flag
        write_txn("R5", 7'h36, 8'd0, with_parity(8'h7F));
        check("R5", "internal flag after accepted write", ca_o[7], 1'b1);
        read_txn("R8", 8'd0);

        // R11: control A reserved bit and clearing internal mode
        write_txn("R11", 7'h36, 8'd8, 8'hFF);
        write_txn("R11", 7'h36, 8'd8, 8'h04);
        check("R11", "ctrl A after 0x04", ca_o, 8'h00);

        // R3: unknown index
        write_txn("R3", 7'h36, 8'd5, 8'h00);
        write_txn("R3", 7'h36, 8'd25, 8'h11);

        // R6: status read-only and readable
        stat = 3'b101;
        write_txn("R6", 7'h36, 8'd24, 8'hFF);
        read_txn("R6", 8'd24);

        // R10: repeated-start read of each register after random writes
        for (int it = 0; it < 30; it++) begin
            sel = 2'($urandom);
            stat = 3'($urandom);
            a7 = ($urandom % 4 == 0) ? 7'($urandom) : {5'b01101, sel};
            case ($urandom % 5)
                0: r = 8'd0;
                1: r = 8'd8;
                2: r = 8'd9;
                3: r = 8'd24;
                default: r = 8'($urandom);
            endcase
            dv = 8'($urandom);
            if (r == 8'd0 && ($urandom % 3 != 0)) dv = with_parity(dv);
            write_txn("R4", a7, r, dv);
            case ($urandom % 4)
                0: r = 8'd0;
                1: r = 8'd8;
                2: r = 8'd9;
                default: r = 8'd24;
            endcase
            read_txn("R10", r);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule